// File: doc/BRIEF.md
# RC5 Infrared Frame Decoder

This block turns the demodulated output of an infrared receiver into RC5 command words. The receiver line is active-low and idles high. The block passes the line through a synchroniser. It waits for a falling edge in the first start bit and confirms the start with a three-sample majority vote inside the second start bit. It then samples every later bit cell once, three quarters of the way through the cell.

All timing comes from a free-running clock-enable tick. The tick period is set by a parameter, so the bit period, the qualification point and the alignment delay are all written as tick counts. This lets the block run from any system clock. When the twelfth data sample is taken, the toggle, address and command fields are latched. A single-cycle strobe marks them valid.

Top module: `ir_frame_decoder`

## Requirements
- R1: During and after reset, `frame_valid` is 0 and `frame_toggle`, `frame_addr` and `frame_cmd` are all 0.
- R2: Bit decoding:
  - A bit cell whose second-half line level is low decodes as 1, and one whose second half is high decodes as 0.
  - The 14 cells arrive as two start bits, the toggle bit, five address bits and six command bits.
  - Address and command arrive most significant bit first.
- R3: For every toggle, address and command value, a well-formed frame produces exactly those values on `frame_toggle`, `frame_addr` and `frame_cmd`.
- R4: Each well-formed frame raises `frame_valid` for exactly one clock cycle. It is never high on two consecutive cycles.
- R5: Sample timing:
  - The first sample is taken `ALIGN_TICKS` ticks after the qualification tick.
  - Each of the 12 data samples follows the previous sample by `BIT_TICKS` ticks.
  - `frame_valid` rises one clock after the last data sample, which falls three quarters of the way into the final cell.
- R6: Start qualification:
  - A start is qualified only by a falling edge followed by a majority-high vote of the line at ticks `QUAL_TICKS-1`, `QUAL_TICKS` and `QUAL_TICKS+1` after the edge.
  - A failed vote discards the attempt, raises no `frame_valid`, and re-arms for the next falling edge.
- R7: The field outputs keep their values until the next complete frame, including across failed starts.
- R8: After reset and after each frame, the line must stay high for `BIT_TICKS` consecutive ticks before a falling edge can start a new frame. A falling edge inside that guard raises no `frame_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_rx_n | input | 1 | Demodulated receiver line, active-low, idles high, asynchronous |
| frame_valid | output | 1 | One-cycle strobe when a new frame has been decoded |
| frame_toggle | output | 1 | Toggle bit of the last decoded frame |
| frame_addr | output | 5 | Address field of the last decoded frame |
| frame_cmd | output | 6 | Command field of the last decoded frame |

## Verification
The strobe is due a fixed number of clocks after a frame begins:
- half a cell to reach the first falling edge,
- about two clocks of synchroniser and edge detection,
- then `QUAL_TICKS + ALIGN_TICKS + 12*BIT_TICKS` ticks of `CLKS_PER_TICK` clocks each.

Because the tick phase is free-running, this landing point has up to one tick of jitter. The bench therefore computes the nominal cycle and accepts the strobe only within a tolerance of one tick plus a few clocks. It records the cycle and fields of each strobe on the falling clock edge. It compares them after the frame's last cell has ended and the guard time has passed. For failed starts and guard-time edges, it watches the full length of a frame and beyond, and requires no strobe and unchanged fields over that whole span.

// File: rtl/ir_dec_pkg.sv
// Package: shared constants and types of the infrared frame decoder.
// Assumes a frame of two start bits, one toggle bit, 5 address and 6 command bits.
package ir_dec_pkg;

    localparam int ADDR_W    = 5;
    localparam int CMD_W     = 6;
    localparam int DATA_BITS = 1 + ADDR_W + CMD_W;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_GUARD = 3'd0,   // waiting for one bit period of idle-high line
        ST_ARMED = 3'd1,   // waiting for a falling edge
        ST_QUAL  = 3'd2,   // counting to the qualification vote
        ST_ALIGN = 3'd3,   // delay from vote to the dummy start-bit sample
        ST_DATA  = 3'd4    // one sample per bit period
    } seq_state_t;

    // Decoded fields of one frame.
    typedef struct packed {
        logic              toggle;
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
    } frame_fields_t;

endpackage

// File: rtl/ir_tick_gen.sv
// Module: ir_tick_gen
// Produces a one-clock enable pulse every CLKS_PER_TICK clocks.
// Assumes CLKS_PER_TICK >= 2. The phase runs free from reset.
module ir_tick_gen #(
    parameter int CLKS_PER_TICK = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int DIV_W = $clog2(CLKS_PER_TICK);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_TICK - 1);

    logic [DIV_W-1:0] div_q;
    logic             tick_q;

    // Divider counter wrapping at the tick period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Registered tick pulse on the last divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= (div_q == DIV_LAST);
        end
    end

    assign tick_o = tick_q;

    // Ticks are isolated pulses, which keeps all tick-counted timing (R5) exact.
    p_tick_isolated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q)
        else $error("tick pulse longer than one clock");

endmodule

// File: rtl/ir_line_sync.sv
// Module: ir_line_sync
// Brings the asynchronous receiver line into the clock domain and flags falling edges.
// Assumes the line idles high. The flops reset to high so that reset makes no false edge.
module ir_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_async_i,
    output logic line_o,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Synchroniser chain, shifting toward the top bit.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_async_i};
            end
        end
    endgenerate

    // Delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign line_o = sync_q[SYNC_STAGES-1];
    assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/ir_frame_seq.sv
// Module: ir_frame_seq
// Sequencer of the decoder: guard time, start qualification, alignment and data sampling.
// Assumes a synchronised line and a one-clock tick.
// Assumes QUAL_TICKS >= 2, ALIGN_TICKS >= 2 and BIT_TICKS >= 2.
module ir_frame_seq
    import ir_dec_pkg::*;
#(
    parameter int BIT_TICKS   = 56,
    parameter int QUAL_TICKS  = 42,
    parameter int ALIGN_TICKS = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          line_i,
    input  logic          fall_i,
    output logic          valid_o,
    output frame_fields_t fields_o
);

    localparam int CNT_MAX0 = (QUAL_TICKS + 1 > BIT_TICKS) ? QUAL_TICKS + 1 : BIT_TICKS;
    localparam int CNT_MAX  = (CNT_MAX0 > ALIGN_TICKS) ? CNT_MAX0 : ALIGN_TICKS;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);
    localparam int BCNT_W   = $clog2(DATA_BITS + 1);

    localparam logic [CNT_W-1:0]  T_BIT_LAST   = CNT_W'(BIT_TICKS - 1);
    localparam logic [CNT_W-1:0]  T_VOTE_A     = CNT_W'(QUAL_TICKS - 2);
    localparam logic [CNT_W-1:0]  T_VOTE_B     = CNT_W'(QUAL_TICKS - 1);
    localparam logic [CNT_W-1:0]  T_DECIDE     = CNT_W'(QUAL_TICKS);
    localparam logic [CNT_W-1:0]  T_ALIGN_LAST = CNT_W'(ALIGN_TICKS - 1);
    localparam logic [BCNT_W-1:0] B_LAST       = BCNT_W'(DATA_BITS - 1);

    seq_state_t           state_q;
    logic [CNT_W-1:0]     tcnt_q;
    logic [BCNT_W-1:0]    bcnt_q;
    logic [1:0]           votes_q;
    logic [DATA_BITS-2:0] shift_q;
    frame_fields_t        fields_q;
    logic                 valid_q;
    logic                 maj;
    logic                 bit_now;
    logic [DATA_BITS-1:0] word;

    // Majority of the two stored votes and the present line level.
    always_comb begin
        maj = (votes_q[1] & votes_q[0]) | (votes_q[1] & line_i) | (votes_q[0] & line_i);
    end

    // Bit value is the inverted second-half level; the word as it would stand after this sample.
    always_comb begin
        bit_now = ~line_i;
        word    = {shift_q, bit_now};
    end

    // Main sequencer: state, tick counter, votes, shift register and output latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_GUARD;
            tcnt_q   <= '0;
            bcnt_q   <= '0;
            votes_q  <= '0;
            shift_q  <= '0;
            fields_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                ST_GUARD: begin
                    if (!line_i) begin
                        tcnt_q <= '0;
                    end else if (tick_i) begin
                        if (tcnt_q == T_BIT_LAST) begin
                            state_q <= ST_ARMED;
                            tcnt_q  <= '0;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                ST_ARMED: begin
                    tcnt_q <= '0;
                    if (fall_i) begin
                        state_q <= ST_QUAL;
                    end
                end
                ST_QUAL: begin
                    if (tick_i) begin
                        tcnt_q <= tcnt_q + 1'b1;
                        if (tcnt_q == T_VOTE_A || tcnt_q == T_VOTE_B) begin
                            votes_q <= {votes_q[0], line_i};
                        end
                        if (tcnt_q == T_DECIDE) begin
                            if (maj) begin
                                state_q <= ST_ALIGN;
                                tcnt_q  <= CNT_W'(1);
                            end else begin
                                state_q <= ST_ARMED;
                                tcnt_q  <= '0;
                            end
                        end
                    end
                end
                ST_ALIGN: begin
                    if (tick_i) begin
                        if (tcnt_q == T_ALIGN_LAST) begin
                            state_q <= ST_DATA;   // this tick is the dummy start-bit sample
                            tcnt_q  <= '0;
                            bcnt_q  <= '0;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (tick_i) begin
                        if (tcnt_q == T_BIT_LAST) begin
                            tcnt_q  <= '0;
                            shift_q <= word[DATA_BITS-2:0];
                            bcnt_q  <= bcnt_q + 1'b1;
                            if (bcnt_q == B_LAST) begin
                                fields_q <= word;
                                valid_q  <= 1'b1;
                                state_q  <= ST_GUARD;
                            end
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_q <= ST_GUARD;
                    tcnt_q  <= '0;
                end
            endcase
        end
    end

    assign valid_o  = valid_q;
    assign fields_o = fields_q;

    // R4: the strobe lasts one clock.
    p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q)
        else $error("valid wider than one clock");

    // R4: the strobe only follows the data sampling phase.
    p_valid_after_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(state_q) == ST_DATA)
        else $error("valid outside data phase");

    // R7: fields move only together with the strobe.
    p_fields_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(fields_q))
        else $error("fields changed without valid");

    // R6: qualification is entered only on a falling edge.
    p_qual_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUAL && $past(state_q) != ST_QUAL) |-> $past(fall_i))
        else $error("qualification without falling edge");

    // R8: leaving the guard needs a high line.
    p_guard_exit_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && $past(state_q) == ST_GUARD) |-> $past(line_i))
        else $error("guard left on low line");

    // R5: no more than the frame's data bits are sampled.
    p_bit_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt_q <= BCNT_W'(DATA_BITS))
        else $error("bit counter overran");

endmodule

// File: rtl/ir_frame_decoder.sv
// Module: ir_frame_decoder (top)
// Decodes RC5 frames from an active-low demodulated infrared line.
// Assumes one tick = CLKS_PER_TICK clocks; all frame timing is given in ticks.
module ir_frame_decoder #(
    parameter int CLKS_PER_TICK = 256,
    parameter int BIT_TICKS     = 56,
    parameter int QUAL_TICKS    = 42,
    parameter int ALIGN_TICKS   = 27,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ir_rx_n,
    output logic       frame_valid,
    output logic       frame_toggle,
    output logic [4:0] frame_addr,
    output logic [5:0] frame_cmd
);

    import ir_dec_pkg::*;

    logic          tick;
    logic          line_s;
    logic          fall_s;
    frame_fields_t fields;

    ir_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    ir_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_async_i (ir_rx_n),
        .line_o       (line_s),
        .fall_o       (fall_s)
    );

    ir_frame_seq #(
        .BIT_TICKS   (BIT_TICKS),
        .QUAL_TICKS  (QUAL_TICKS),
        .ALIGN_TICKS (ALIGN_TICKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .line_i   (line_s),
        .fall_i   (fall_s),
        .valid_o  (frame_valid),
        .fields_o (fields)
    );

    assign frame_toggle = fields.toggle;
    assign frame_addr   = fields.addr;
    assign frame_cmd    = fields.cmd;

endmodule

// File: tb/sim_ir_frame_decoder.sv
// Bench for ir_frame_decoder on a small timing configuration: 4 clocks per tick, 16 ticks per bit.
module sim_ir_frame_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int CPT   = 4;
    localparam int BITT  = 16;
    localparam int QUALT = 12;
    localparam int ALNT  = 8;
    localparam int HALF  = BITT * CPT / 2;
    localparam int NOMINAL = HALF + 2 + (QUALT + ALNT + 12 * BITT) * CPT;
    localparam int TOL   = CPT + 6;
    localparam int WATCHDOG = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_rx_n = 1'b1;
    logic       frame_valid;
    logic       frame_toggle;
    logic [4:0] frame_addr;
    logic [5:0] frame_cmd;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int vcnt = 0;
    int vcyc = 0;
    int wide = 0;
    bit prev_v = 1'b0;
    logic       cap_t;
    logic [4:0] cap_a;
    logic [5:0] cap_c;

    ir_frame_decoder #(
        .CLKS_PER_TICK (CPT),
        .BIT_TICKS     (BITT),
        .QUAL_TICKS    (QUALT),
        .ALIGN_TICKS   (ALNT),
        .SYNC_STAGES   (2)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ir_rx_n      (ir_rx_n),
        .frame_valid  (frame_valid),
        .frame_toggle (frame_toggle),
        .frame_addr   (frame_addr),
        .frame_cmd    (frame_cmd)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Strobe monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_valid) begin
                vcnt  = vcnt + 1;
                vcyc  = cyc;
                cap_t = frame_toggle;
                cap_a = frame_addr;
                cap_c = frame_cmd;
                if (prev_v) wide = wide + 1;
            end
            prev_v = frame_valid;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        ir_rx_n = lvl;
        repeat (n) @(negedge clk);
    endtask

    // Drives one frame: each cell is the bit level then its inverse on the line.
    task automatic send_frame(input logic t, input logic [4:0] a, input logic [5:0] c);
        logic [13:0] bits;
        bits = {2'b11, t, a, c};
        for (int k = 13; k >= 0; k--) begin
            hold(bits[k], HALF);
            hold(~bits[k], HALF);
        end
    endtask

    // Sends a frame and checks count, timing and fields (R2/R3 decode, R4 count, R5 timing).
    task automatic run_frame(input logic t, input logic [4:0] a, input logic [5:0] c, input string req);
        int c0;
        int v0;
        c0 = cyc;
        v0 = vcnt;
        send_frame(t, a, c);
        hold(1'b1, 100);
        chk(vcnt == v0 + 1, {req, "/R4 strobe count"}, vcnt - v0, 1);
        chk((vcyc - c0 >= NOMINAL - TOL) && (vcyc - c0 <= NOMINAL + TOL),
            "R5 strobe time", vcyc - c0, NOMINAL);
        chk({cap_t, cap_a, cap_c} == {t, a, c}, {req, " fields"},
            int'({cap_t, cap_a, cap_c}), int'({t, a, c}));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int v0;
        logic [11:0] keep;
        repeat (5) @(negedge clk);
        // R1: reset state while held in reset
        chk(frame_valid == 1'b0, "R1 valid in reset", frame_valid, 0);
        chk({frame_toggle, frame_addr, frame_cmd} == 12'd0, "R1 fields in reset",
            int'({frame_toggle, frame_addr, frame_cmd}), 0);
        rst_n = 1'b1;
        hold(1'b1, 100);
        chk(vcnt == 0 && frame_valid == 1'b0, "R1 idle after reset", vcnt, 0);

        // R2: bit sense and field order on single-bit patterns
        run_frame(1'b1, 5'h10, 6'h01, "R2");
        run_frame(1'b0, 5'h01, 6'h20, "R2");
        run_frame(1'b1, 5'h1F, 6'h3F, "R2");
        run_frame(1'b0, 5'h00, 6'h00, "R2");

        // R3: every command, every address, both toggle values
        for (int i = 0; i < 64; i++) begin
            run_frame(1'(i[0] ^ i[3]), 5'((i * 7) % 32), 6'(i), "R3");
        end

        // R6: falling edge followed by a low line at the vote point
        keep = {frame_toggle, frame_addr, frame_cmd};
        v0 = vcnt;
        hold(1'b0, 100);
        hold(1'b1, 1100);
        chk(vcnt == v0, "R6 no strobe on failed start", vcnt - v0, 0);
        hold(1'b0, 150);
        hold(1'b1, 1100);
        chk(vcnt == v0, "R6 no strobe on long low", vcnt - v0, 0);
        // R7: fields held across failed starts
        chk({frame_toggle, frame_addr, frame_cmd} == keep, "R7 fields held",
            int'({frame_toggle, frame_addr, frame_cmd}), int'(keep));

        // R6: decoder re-armed after a failed start
        run_frame(1'b1, 5'h0A, 6'h15, "R6");

        // R8: a falling edge right after a frame, inside the guard time
        v0 = vcnt;
        send_frame(1'b0, 5'h13, 6'h3E);
        hold(1'b0, 12);
        hold(1'b1, 1100);
        chk(vcnt == v0 + 1, "R8 no strobe inside guard", vcnt - v0, 1);
        chk({frame_toggle, frame_addr, frame_cmd} == {1'b0, 5'h13, 6'h3E}, "R8 fields kept",
            int'({frame_toggle, frame_addr, frame_cmd}), int'({1'b0, 5'h13, 6'h3E}));
        run_frame(1'b1, 5'h05, 6'h2A, "R8");

        // R4: strobe never wider than one clock
        chk(wide == 0, "R4 strobe width", wide, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule